// File: doc/BRIEF.md
# PCI Interrupt Status and Mask Controller

This block collects interrupt events raised by a PCI interface into a sticky status register. It gates them through a per-source mask and a single global enable, then drives one combined interrupt line towards the CPU. Software reaches the three registers, plus one acknowledge register, through a simple word-addressed read/write port. Status bits are cleared by writing ones to them.

Event inputs may be one-cycle pulses or held levels. Either form sets the matching status bit, and the bit stays set until software clears it. The block also reports which pending source has the lowest bit index, so that a dispatcher can serve sources in a fixed order. A combined acknowledge register clears the mask bit and the status bit of a source in one write.

Top module: `pci_irq_ctrl`

## Requirements
- R1: After reset the status, mask and enable registers are zero, reads of every register return zero, `irq_o` is low and `pend_valid_o` is low.
- R2: Only bit positions 0 to 7, 9, 25 and 26 hold status. An event bit high at a clock edge sets the matching status bit, which stays set after the event drops. All other bits always read as zero.
- R3: A write to the status register at offset 0x500 clears each status bit whose write-data bit is one. Bits written with zero keep their value.
- R4: When an event and a clearing write hit the same status bit at the same edge, the bit remains set.
- R5: The mask register at offset 0x504 stores write data at the source positions and reads back with all other bits at zero.
- R6: Bit 0 of the enable register at offset 0x508 is written from write-data bit 0. Reads of this register return that bit, with every other bit zero.
- R7: `irq_o` is high exactly when the enable bit is set and some bit is set in both status and mask. It follows a register change at the same edge that changes the register.
- R8: `pend_valid_o` is high when any status-and-mask bit is set. `pend_idx_o` then gives the lowest such bit index, regardless of the enable bit.
- R9: A write to the acknowledge register at offset 0x50C clears, for each write-data bit that is one, both the mask bit and the status bit. A concurrent event still keeps its status bit set. The register reads as zero.
- R10: Reads of any other offset return zero, and writes to it change no register.
- R11: `rdata_o` carries the value addressed by a read one cycle after `rd_en_i` is sampled high, and holds that value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (12) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| evt_i | input | DATA_W (32) | Event inputs, one per status bit position |
| irq_o | output | 1 | Combined interrupt to the CPU |
| pend_valid_o | output | 1 | Some source is pending |
| pend_idx_o | output | IDX_W (5) | Lowest pending source index |

## Verification
Register writes and events land at the clock edge where they are sampled. The interrupt line, the pending flag and the pending index therefore settle within that same cycle. The bench drives inputs on the falling edge and samples these outputs on the following falling edge. Read data is due one cycle after the read strobe is sampled. For this reason the read task queues its expected word when it drives the strobe, and a monitor compares it on the falling edge after the next rising edge. The same-edge collision between an event and a clear is driven within a single cycle, and its result is read back afterwards.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

   localparam int unsigned REG_W = 32;

   localparam logic [11:0] OFS_STATUS = 12'h500;
   localparam logic [11:0] OFS_MASK   = 12'h504;
   localparam logic [11:0] OFS_ENABLE = 12'h508;
   localparam logic [11:0] OFS_ACK    = 12'h50C;

   // source positions that carry state
   localparam int unsigned SRC_INB_LAST  = 7;   // bits 0..7 form a contiguous group
   localparam int unsigned SRC_INB_EMPTY = 9;
   localparam int unsigned SRC_EXT_INTA  = 25;
   localparam int unsigned SRC_BUS_ABORT = 26;
   localparam int unsigned SRC_TOP       = SRC_BUS_ABORT;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_MASK,
      SEL_ENABLE,
      SEL_ACK
   } reg_sel_e;

   typedef struct packed {
      logic clr_status;
      logic load_mask;
      logic load_enable;
      logic ack;
   } wr_strobe_t;

   function automatic bit is_source(int unsigned pos);
      return (pos <= SRC_INB_LAST) || (pos == SRC_INB_EMPTY) ||
             (pos == SRC_EXT_INTA) || (pos == SRC_BUS_ABORT);
   endfunction

   function automatic logic [63:0] source_vector();
      logic [63:0] v;
      v = '0;
      for (int unsigned k = 0; k < 64; k++) begin
         v[k] = is_source(k);
      end
      return v;
   endfunction

endpackage

// File: rtl/pci_irq_regif.sv
module pci_irq_regif
   import pci_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              enable_i,
   output wr_strobe_t        stb_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

   reg_sel_e          sel;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      unique case (addr_i)
         A_STATUS: sel = SEL_STATUS;
         A_MASK:   sel = SEL_MASK;
         A_ENABLE: sel = SEL_ENABLE;
         A_ACK:    sel = SEL_ACK;
         default:  sel = SEL_NONE;
      endcase
   end

   always_comb begin
      stb_o             = '0;
      stb_o.clr_status  = wr_en_i && (sel == SEL_STATUS);
      stb_o.load_mask   = wr_en_i && (sel == SEL_MASK);
      stb_o.load_enable = wr_en_i && (sel == SEL_ENABLE);
      stb_o.ack         = wr_en_i && (sel == SEL_ACK);
   end

   always_comb begin
      case (sel)
         SEL_STATUS: rd_mux = status_i;
         SEL_MASK:   rd_mux = mask_i;
         SEL_ENABLE: rd_mux = {{(DATA_W-1){1'b0}}, enable_i};
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         rdata_q <= rd_mux;
      end
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/pci_irq_status.sv
module pci_irq_status
   import pci_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] clr_i,
   output logic [DATA_W-1:0] status_o
);

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (is_source(g)) begin : g_live
         logic flag_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               flag_q <= 1'b0;
            end else if (evt_i[g]) begin
               flag_q <= 1'b1;
            end else if (clr_i[g]) begin
               flag_q <= 1'b0;
            end
         end
         assign status_o[g] = flag_q;
      end else begin : g_tied
         assign status_o[g] = 1'b0;
      end
   end

endmodule

// File: rtl/pci_irq_mask.sv
module pci_irq_mask
   import pci_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_mask_i,
   input  logic              load_enable_i,
   input  logic [DATA_W-1:0] ack_clr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o,
   output logic              enable_o
);

   logic enable_q;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      if (is_source(g)) begin : g_live
         logic m_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               m_q <= 1'b0;
            end else if (ack_clr_i[g]) begin
               m_q <= 1'b0;
            end else if (load_mask_i) begin
               m_q <= wdata_i[g];
            end
         end
         assign mask_o[g] = m_q;
      end else begin : g_tied
         assign mask_o[g] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enable_q <= 1'b0;
      end else if (load_enable_i) begin
         enable_q <= wdata_i[0];
      end
   end

   assign enable_o = enable_q;

endmodule

// File: rtl/pci_irq_prio.sv
module pci_irq_prio #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [DATA_W-1:0] vec_i,
   output logic              valid_o,
   output logic [IDX_W-1:0]  idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            idx_o = IDX_W'(i);
         end
      end
   end

   assign valid_o = |vec_i;

endmodule

// File: rtl/pci_irq_ctrl.sv
module pci_irq_ctrl
   import pci_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [DATA_W-1:0] evt_i,
   output logic              irq_o,
   output logic              pend_valid_o,
   output logic [IDX_W-1:0]  pend_idx_o
);

   if (DATA_W <= SRC_TOP || DATA_W > 64) begin : g_bad_width
      $error("DATA_W must cover every source position and stay within 64");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end
   if ((1 << IDX_W) < DATA_W) begin : g_bad_idx
      $error("IDX_W cannot index every bit");
   end

   wr_strobe_t        stb;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;
   logic              en_q;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] ack_vec;
   logic [DATA_W-1:0] pending;

   assign ack_vec = stb.ack ? wdata_i : '0;
   assign clr_vec = (stb.clr_status ? wdata_i : '0) | ack_vec;

   pci_irq_regif #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) regif_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .rd_en_i  (rd_en_i),
      .addr_i   (addr_i),
      .status_i (status_q),
      .mask_i   (mask_q),
      .enable_i (en_q),
      .stb_o    (stb),
      .rdata_o  (rdata_o)
   );

   pci_irq_status #(
      .DATA_W (DATA_W)
   ) status_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .clr_i    (clr_vec),
      .status_o (status_q)
   );

   pci_irq_mask #(
      .DATA_W (DATA_W)
   ) mask_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .load_mask_i   (stb.load_mask),
      .load_enable_i (stb.load_enable),
      .ack_clr_i     (ack_vec),
      .wdata_i       (wdata_i),
      .mask_o        (mask_q),
      .enable_o      (en_q)
   );

   assign pending = status_q & mask_q;

   pci_irq_prio #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) prio_i (
      .vec_i   (pending),
      .valid_o (pend_valid_o),
      .idx_o   (pend_idx_o)
   );

   assign irq_o = en_q & pend_valid_o;

endmodule

// File: rtl/pci_irq_ctrl_chk.sv
module pci_irq_ctrl_chk
   import pci_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic [DATA_W-1:0] evt_i,
   input logic              irq_o,
   input logic              pend_valid_o,
   input logic [IDX_W-1:0]  pend_idx_o,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              en_q
);

   localparam logic [63:0]       ALL_SRC = source_vector();
   localparam logic [DATA_W-1:0] SRC_VEC = ALL_SRC[DATA_W-1:0];
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

   p_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q | mask_q) & ~SRC_VEC) == '0);

   p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evt_i & SRC_VEC) != '0) |=> ((status_q & $past(evt_i & SRC_VEC)) == $past(evt_i & SRC_VEC)));

   p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (en_q && pend_valid_o));

   p_irq_raised_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && ((status_q & mask_q) != '0)) |-> irq_o);

   p_idx_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_valid_o |-> (status_q[pend_idx_o] && mask_q[pend_idx_o]));

   p_idx_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_valid_o |-> (((status_q & mask_q) & ((DATA_W'(1) << pend_idx_o) - DATA_W'(1))) == '0));

   p_ack_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_ACK) |=> ((mask_q & $past(wdata_i)) == '0));

   p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));

endmodule

bind pci_irq_ctrl pci_irq_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .rd_en_i      (rd_en_i),
   .addr_i       (addr_i),
   .wdata_i      (wdata_i),
   .rdata_o      (rdata_o),
   .evt_i        (evt_i),
   .irq_o        (irq_o),
   .pend_valid_o (pend_valid_o),
   .pend_idx_o   (pend_idx_o),
   .status_q     (status_q),
   .mask_q       (mask_q),
   .en_q         (en_q)
);

// File: tb/pci_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pci_irq_ctrl_tb_top;

   localparam logic [11:0] A_STAT = 12'h500;
   localparam logic [11:0] A_MASK = 12'h504;
   localparam logic [11:0] A_EN   = 12'h508;
   localparam logic [11:0] A_ACK  = 12'h50C;
   localparam logic [11:0] A_NONE = 12'h510;
   localparam logic [31:0] SRC    = 32'h0600_02FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] evt = '0;
   logic        irq;
   logic        pvalid;
   logic [4:0]  pidx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t rd_q[$];
   logic     rd_seen = 1'b0;

   always #4 clk = ~clk;

   pci_irq_ctrl dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .wr_en_i      (wr_en),
      .rd_en_i      (rd_en),
      .addr_i       (addr),
      .wdata_i      (wdata),
      .rdata_o      (rdata),
      .evt_i        (evt),
      .irq_o        (irq),
      .pend_valid_o (pvalid),
      .pend_idx_o   (pidx)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data one cycle after the strobe is sampled
   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (rd_q.size() == 0) begin
            chk("R11 unexpected read data", 32'h1, 32'h0);
         end else begin
            rd_item_t it;
            it = rd_q.pop_front();
            chk(it.tag, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.exp = exp; it.tag = tag;
      rd_q.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] bits);
      @(negedge clk);
      evt = bits;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic outs(input string tag, input logic e_irq, input logic e_val, input logic [4:0] e_idx);
      chk({tag, " irq"}, {31'b0, irq}, {31'b0, e_irq});
      chk({tag, " valid"}, {31'b0, pvalid}, {31'b0, e_val});
      if (e_val) chk({tag, " idx"}, {27'b0, pidx}, {27'b0, e_idx});
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      outs("R1 reset", 1'b0, 1'b0, 5'd0);
      rd(A_STAT, 32'h0, "R1 status reset");
      rd(A_MASK, 32'h0, "R1 mask reset");
      rd(A_EN,   32'h0, "R1 enable reset");
      rd(A_ACK,  32'h0, "R1 ack reset");

      // R2 all events: only source bits stick
      pulse(32'hFFFF_FFFF);
      rd(A_STAT, SRC, "R2 sticky source bits");
      outs("R7 masked", 1'b0, 1'b0, 5'd0);

      // R5 mask
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, SRC, "R5 mask readback");
      outs("R7 disabled", 1'b0, 1'b1, 5'd0);

      // R6 enable
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, 32'h1, "R6 enable readback");
      outs("R7 enabled", 1'b1, 1'b1, 5'd0);

      // R3 write one to clear
      wr(A_STAT, 32'h0000_00FF);
      outs("R8 after clear low group", 1'b1, 1'b1, 5'd9);
      wr(A_STAT, 32'h0);
      rd(A_STAT, 32'h0600_0200, "R3 zero write keeps bits");

      // R4 event and clear at the same edge
      @(negedge clk);
      wr_en = 1'b1; addr = A_STAT; wdata = 32'h200; evt = 32'h200;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; evt = '0;
      rd(A_STAT, 32'h0600_0200, "R4 event beats clear");

      // R9 acknowledge
      wr(A_ACK, 32'h200);
      rd(A_MASK, 32'h0600_00FF, "R9 ack clears mask");
      rd(A_STAT, 32'h0600_0000, "R9 ack clears status");
      rd(A_ACK,  32'h0, "R9 ack reads zero");
      outs("R8 next source", 1'b1, 1'b1, 5'd25);

      wr(A_STAT, 32'h0200_0000);
      outs("R8 abort source", 1'b1, 1'b1, 5'd26);

      // R6 disable
      wr(A_EN, 32'h0);
      outs("R6 disabled", 1'b0, 1'b1, 5'd26);

      // R10 unmapped offset
      wr(A_NONE, 32'hFFFF_FFFF);
      rd(A_NONE, 32'h0, "R10 unmapped read");
      rd(A_STAT, 32'h0400_0000, "R10 unmapped write ignored");

      // R11 hold without read
      pulse(32'h1);
      chk("R11 rdata hold", rdata, 32'h0400_0000);
      outs("R8 low source", 1'b0, 1'b1, 5'd0);

      // R2 level input held across a clear
      @(negedge clk);
      evt = 32'h20;
      wr(A_STAT, 32'h20);
      rd(A_STAT, 32'h0400_0021, "R2 level held");
      @(negedge clk);
      evt = '0;
      wr(A_STAT, 32'h20);
      rd(A_STAT, 32'h0400_0001, "R3 clear after level drops");

      wr(A_EN, 32'h1);
      outs("R7 re-enabled", 1'b1, 1'b1, 5'd0);
      wr(A_STAT, 32'h0400_0001);
      outs("R7 all cleared", 1'b0, 1'b0, 5'd0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule